// File: doc/BRIEF.md
# Supervised Memory Access Controller

This block fronts a small memory in which every location carries a data word plus a 2-bit metadata tag. Each request is either supervised or plain, and is either a load or a store. A supervised access reads the tag of the target location. It then looks up a next tag in a programmable transition table, indexed by operation and current tag. If the table returns the reserved trap code, the access is aborted: nothing in the memory changes, and the response flags an exception together with the faulting address. Otherwise the tag is rewritten when it changes, and the data is read or written. Plain accesses skip the tag check entirely.

Requests arrive on a valid/ready channel, and results leave on a second valid/ready channel. A request is taken only when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` stays low from that edge until the response has been taken (`rsp_valid` and `rsp_ready` both high). Only one access is ever in flight, so the tag read, tag update and data access form one indivisible step. While `rsp_ready` is low, the response is held unchanged. The table is written through a plain configuration port.

Top module: `supmem_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. Every tag is Empty (code 0). The table holds the empty/full defaults: a store to Empty yields Full (code 1), a load from Empty yields the trap code 3, and every other entry keeps its tag unchanged.
- R2: A supervised store to an Empty location writes the data, sets the tag to Full, and responds with `rsp_exc`=0 and `rsp_meta`=1.
- R3: A supervised access whose table entry is the trap code 3 responds with `rsp_exc`=1, `rsp_addr` equal to the request address and `rsp_rdata`=0. It leaves both the data and the tag of that location unchanged.
- R4: A supervised load that does not trap returns the stored data in `rsp_rdata`, and `rsp_meta` carries the tag after the access.
- R5: A pulse on `cfg_we` writes `cfg_next` into the entry selected by `cfg_store` (1 = store) and `cfg_state`. Later supervised accesses follow the new entry.
- R6: Plain accesses (`req_sup`=0) never trap and never change a tag. `rsp_meta` reports the unchanged tag of the location.
- R7: `req_ready` is 0 from the edge that accepts a request until the edge at which its response is taken.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata`, `rsp_meta`, `rsp_exc` and `rsp_addr` hold their values.
- R9: A `cfg_we` pulse is ignored while an access is in flight (`req_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_sup | input | 1 | 1 = supervised, 0 = plain |
| req_addr | input | ADDR_W | Target location |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Data before the access (0 on a trap) |
| rsp_meta | output | 2 | Tag after the access |
| rsp_exc | output | 1 | Access trapped |
| rsp_addr | output | ADDR_W | Address of the access (faulting address on a trap) |
| cfg_we | input | 1 | Table write strobe |
| cfg_store | input | 1 | Table half: 1 = store, 0 = load |
| cfg_state | input | 2 | Current-tag index of the entry |
| cfg_next | input | 2 | Next tag to write |

## Verification
The bench goes after a supervised load of an Empty location. A controller that traps late would corrupt the data or the tag. One that forgets the trap would hand back data with no exception. Plain stores and loads of untagged locations are checked so that a design leaking tag updates into the bypass path would show a changed tag. Rewritten table entries, and a table write slipped in mid-access, are used to catch a lookup wired to stale or unguarded entries. A stalled response is held for several cycles to expose a design that drops or alters a result under back-pressure or accepts a second request early.

// File: rtl/supmem_pkg.sv
package supmem_pkg;
  localparam int TAG_W = 2;
  typedef logic [TAG_W-1:0] tag_t;
  localparam tag_t TAG_EMPTY = 2'd0;
  localparam tag_t TAG_FULL  = 2'd1;
  localparam tag_t TAG_TRAP  = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_RESP} phase_e;

  function automatic tag_t dflt_next(input logic is_store, input tag_t cur);
    if (cur == TAG_EMPTY) return is_store ? TAG_FULL : TAG_TRAP;
    return cur;
  endfunction
endpackage

// File: rtl/supmem_ttable.sv
module supmem_ttable
  import supmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_store,
  input  tag_t wr_state,
  input  tag_t wr_next,
  input  logic lk_store,
  input  tag_t lk_state,
  output tag_t lk_next
);
  localparam int ENTRIES = 2 * (1 << TAG_W);
  localparam int IDX_W = TAG_W + 1;

  tag_t entry [ENTRIES];
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] lk_idx;
  assign wr_idx = {wr_store, wr_state};
  assign lk_idx = {lk_store, lk_state};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) entry[i] <= dflt_next(ME[IDX_W-1], ME[TAG_W-1:0]);
      else if (wr_en && wr_idx == ME) entry[i] <= wr_next;
    end
  end

  assign lk_next = entry[lk_idx];

  // R9: without a granted write, the looked-up entry cannot move
  assert_tbl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> entry[$past(lk_idx)] == $past(lk_next));
endmodule

// File: rtl/supmem_store.sv
module supmem_store
  import supmem_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output tag_t              rd_tag,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_we,
  input  tag_t              wr_tag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  tag_t              tag_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        data_mem[i] <= '0;
        tag_mem[i]  <= TAG_EMPTY;
      end
    end else begin
      if (data_we) data_mem[addr] <= wr_data;
      if (tag_we)  tag_mem[addr]  <= wr_tag;
    end
  end

  assign rd_data = data_mem[addr];
  assign rd_tag  = tag_mem[addr];

  // R3: the trap code never lands in the tag array
  assert_no_trap_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> wr_tag != TAG_TRAP);
endmodule

// File: rtl/supmem_ctrl.sv
module supmem_ctrl
  import supmem_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic              req_sup,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_meta,
  output logic              rsp_exc,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              cfg_we,
  input  logic              cfg_store,
  input  logic [1:0]        cfg_state,
  input  logic [1:0]        cfg_next
);
  phase_e            phase;
  logic              q_store, q_sup;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;

  logic [DATA_W-1:0] cur_data;
  tag_t              cur_tag, nxt_tag;
  logic              trap, tag_we, data_we;

  assign req_ready = (phase == PH_IDLE);
  assign rsp_valid = (phase == PH_RESP);

  supmem_ttable u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && req_ready), .wr_store(cfg_store),
    .wr_state(cfg_state), .wr_next(cfg_next),
    .lk_store(q_store), .lk_state(cur_tag), .lk_next(nxt_tag)
  );

  supmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(q_addr),
    .rd_data(cur_data), .rd_tag(cur_tag),
    .data_we(data_we), .wr_data(q_wdata),
    .tag_we(tag_we), .wr_tag(nxt_tag)
  );

  always_comb begin
    trap    = 1'b0;
    tag_we  = 1'b0;
    data_we = 1'b0;
    if (phase == PH_EXEC) begin
      trap    = q_sup && (nxt_tag == TAG_TRAP);
      tag_we  = q_sup && !trap && (nxt_tag != cur_tag);
      data_we = q_store && !trap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      q_store   <= 1'b0;
      q_sup     <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
      rsp_rdata <= '0;
      rsp_meta  <= TAG_EMPTY;
      rsp_exc   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (req_valid) begin
          q_store <= req_store;
          q_sup   <= req_sup;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          phase   <= PH_EXEC;
        end
        PH_EXEC: begin
          rsp_rdata <= trap ? '0 : cur_data;
          rsp_meta  <= (q_sup && !trap) ? nxt_tag : cur_tag;
          rsp_exc   <= trap;
          rsp_addr  <= q_addr;
          phase     <= PH_RESP;
        end
        PH_RESP: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7: no new request while a response is pending
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R8: stalled response stays put
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) &&
      $stable(rsp_meta) && $stable(rsp_exc) && $stable(rsp_addr));
  // R6: plain accesses never touch a tag
  assert_plain_no_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EXEC && !q_sup |-> !tag_we);
  // R3: a trapped response carries no data
  assert_trap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_exc |-> rsp_rdata == '0);
endmodule

// File: tb/supmem_ctrl_bench.sv
module supmem_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, req_sup = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_exc;
  logic rsp_ready = 1;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] rsp_meta;
  logic [AW-1:0] rsp_addr;
  logic cfg_we = 0, cfg_store = 0;
  logic [1:0] cfg_state = 0, cfg_next = 0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [DW-1:0] g_data;
  logic [1:0] g_meta;
  logic g_exc;
  logic [AW-1:0] g_addr;

  always #2 clk = ~clk;

  supmem_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_supmem_ctrl (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic sup, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1; req_store = st; req_sup = sup; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 20 && !rsp_valid; i++) @(negedge clk);
    g_data = rsp_rdata; g_meta = rsp_meta; g_exc = rsp_exc; g_addr = rsp_addr;
    chk("R7 response arrives", rsp_valid, 1);
    @(negedge clk);
  endtask

  task automatic prog(input logic st, input logic [1:0] s, input logic [1:0] n);
    @(negedge clk);
    cfg_we = 1; cfg_store = st; cfg_state = s; cfg_next = n;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no response after reset", rsp_valid, 0);
    access(0, 0, 4'd5, 0);
    chk("R1 tag Empty", g_meta, 0);
    chk("R1 data zero", g_data, 0);
  endtask

  task automatic t_load_empty;
    access(0, 1, 4'd5, 0);
    chk("R3 trap flag", g_exc, 1);
    chk("R3 fault addr", g_addr, 5);
    chk("R3 zero data", g_data, 0);
    access(0, 0, 4'd5, 0);
    chk("R3 tag unchanged", g_meta, 0);
  endtask

  task automatic t_store_empty;
    access(1, 1, 4'd5, 16'hBEEF);
    chk("R2 no trap", g_exc, 0);
    chk("R2 tag Full", g_meta, 1);
    access(0, 0, 4'd5, 0);
    chk("R2 data written", g_data, 16'hBEEF);
    chk("R2 tag stored Full", g_meta, 1);
    access(0, 1, 4'd5, 0);
    chk("R4 load data", g_data, 16'hBEEF);
    chk("R4 tag stays Full", g_meta, 1);
    chk("R4 no trap", g_exc, 0);
  endtask

  task automatic t_plain;
    access(1, 0, 4'd9, 16'h1234);
    chk("R6 plain store no trap", g_exc, 0);
    chk("R6 plain store tag", g_meta, 0);
    access(0, 0, 4'd9, 0);
    chk("R6 plain load data", g_data, 16'h1234);
    chk("R6 plain load tag", g_meta, 0);
    access(0, 1, 4'd9, 0);
    chk("R6 tag still Empty so trap", g_exc, 1);
  endtask

  task automatic t_program;
    prog(0, 2'd1, 2'd0);           // load of Full empties
    access(0, 1, 4'd5, 0);
    chk("R5 consumed load data", g_data, 16'hBEEF);
    chk("R5 consumed load tag", g_meta, 0);
    access(0, 1, 4'd5, 0);
    chk("R5 second load traps", g_exc, 1);
    prog(1, 2'd1, 2'd3);           // store to Full traps
    access(1, 1, 4'd5, 16'h0A0A);
    chk("R5 store fills", g_meta, 1);
    access(1, 1, 4'd5, 16'h5555);
    chk("R3 store trap", g_exc, 1);
    access(0, 0, 4'd5, 0);
    chk("R3 trapped store left data", g_data, 16'h0A0A);
    chk("R3 trapped store left tag", g_meta, 1);
    prog(0, 2'd1, 2'd1);
    prog(1, 2'd1, 2'd1);
  endtask

  task automatic t_backpressure;
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_store = 0; req_sup = 0; req_addr = 4'd9;
    @(negedge clk);
    chk("R7 ready low after accept", req_ready, 0);
    req_addr = 4'd5;                // still valid, must not be taken
    for (int i = 0; i < 20 && !rsp_valid; i++) @(negedge clk);
    g_data = rsp_rdata;
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R8 valid held", rsp_valid, 1);
    chk("R8 data held", rsp_rdata, g_data);
    chk("R8 data value", rsp_rdata, 16'h1234);
    chk("R7 ready low while stalled", req_ready, 0);
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    chk("R7 ready after take", req_ready, 1);
    chk("R8 response gone", rsp_valid, 0);
  endtask

  task automatic t_cfg_busy;
    @(negedge clk);
    req_valid = 1; req_store = 0; req_sup = 0; req_addr = 4'd3;
    @(negedge clk);
    req_valid = 0;
    cfg_we = 1; cfg_store = 0; cfg_state = 2'd0; cfg_next = 2'd0;
    @(negedge clk);
    cfg_we = 0;
    for (int i = 0; i < 20 && !rsp_valid; i++) @(negedge clk);
    @(negedge clk);
    access(0, 1, 4'd3, 0);
    chk("R9 busy write ignored", g_exc, 1);
    prog(0, 2'd0, 2'd0);
    access(0, 1, 4'd3, 0);
    chk("R5 idle write taken", g_exc, 0);
    chk("R5 tag kept Empty", g_meta, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_empty();
    t_store_empty();
    t_plain();
    t_program();
    t_backpressure();
    t_cfg_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule